// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter and Bus Sequencer

This block sits between four peripheral request lines and a host processor's bus-hold handshake. When an enabled channel raises its request, the block asks the host for the bus and waits for the host's acknowledge. It then grants one channel at a time through an active-low acknowledge line and sequences a transfer lasting exactly four clocks. Each transfer is typed per channel as a read (memory to I/O), a write (I/O to memory) or a verify, which walks the same sequence but drives no strobes.

Two priority schemes can be selected. In fixed priority the lowest channel number wins. In rotating priority the channel just served drops to the bottom of the order. When several channels are pending, transfers run back to back without releasing the bus. If the host withdraws its acknowledge, the current transfer finishes and no further transfer starts until the acknowledge returns. Each channel counts down a programmed number of transfers. The last transfer sets a terminal-count flag in a read-only status register and disables that channel.

A small CPU register port loads per-channel setup and a write-only mode register. The mode register shares its address with the read-only status register. Reading status clears its flags.

Top module: `dma_req_ctrl`

## Requirements
- R1: With the block idle, an enabled channel's request sampled at a clock edge raises `hold_req_o` after that edge. No acknowledge or strobe goes active until `hold_ack_i` is seen high.
- R2: At most one `dack_no` bit is low at a time. A granted channel's line stays low for exactly four clocks for each transfer.
- R3: Transfer type is bits [7:6] of the channel register: 2'b10 read, 2'b01 write, 2'b00 or 2'b11 verify. In clocks 2 and 3 of a transfer, a read drives `mem_rd_no` and `io_wr_no` low, and a write drives `io_rd_no` and `mem_wr_no` low. A verify drives no strobe. No strobe is active in clocks 1 and 4.
- R4: With mode bit 4 clear (fixed), the lowest-numbered pending enabled channel is granted.
- R5: With mode bit 4 set (rotating), the search starts at the channel after the one last served, wrapping from 3 to 0. Reset starts the search at channel 0.
- R6: While requests remain and `hold_ack_i` stays high, the next transfer's first clock follows the previous transfer's fourth clock directly, with `hold_req_o` held high.
- R7: If `hold_ack_i` falls during a transfer, that transfer completes its four clocks. No new grant follows while `hold_ack_i` is low, and `hold_req_o` stays high while requests remain.
- R8: After the fourth clock of a transfer, if no enabled channel is requesting, `hold_req_o` falls on the next clock.
- R9: Channel register bits [5:0] hold the transfer count minus one; writes use addresses 0 to 3. On the final transfer, `term_cnt_o` is high in its fourth clock. The channel's status bit is then set and its enable bit is cleared, so further requests from it are ignored.
- R10: Address 4 writes the mode register: bits [3:0] are channel enables and bit 4 selects the scheme. A read of address 4 returns the terminal-count flags in bits [3:0] and zeros above, never the mode bits. The read clears the flags. Requests from disabled channels never raise `hold_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dreq_i | input | 4 | Per-channel service requests, active high |
| hold_req_o | output | 1 | Bus hold request to the host |
| hold_ack_i | input | 1 | Bus hold acknowledge from the host |
| dack_no | output | 4 | Per-channel grant, active low |
| mem_rd_no | output | 1 | Memory read strobe, active low |
| mem_wr_no | output | 1 | Memory write strobe, active low |
| io_rd_no | output | 1 | I/O read strobe, active low |
| io_wr_no | output | 1 | I/O write strobe, active low |
| term_cnt_o | output | 1 | High in the last clock of a channel's final transfer |
| reg_cs_i | input | 1 | Register port select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address: 0-3 channel setup, 4 mode/status |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |

## Verification
The bench targets the edges between transfers. It checks that the next grant follows the fourth clock without a gap, where a slow arbiter would insert an idle clock or drop the hold request. It checks that a rotating pointer advances from the channel actually served, where a wrong pointer would repeat a channel. The bench also withdraws the host acknowledge in mid-transfer: an unsafe design would truncate the transfer or start another one without the bus. The final transfer of a channel is checked for the terminal-count pulse and the auto-disable, where an off-by-one counter would give one transfer too many or too few. The bench confirms that a status read returns flags rather than mode bits and clears them.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_XFER} dma_state_e;
  localparam logic [1:0] XT_VERIFY = 2'b00;
  localparam logic [1:0] XT_WRITE  = 2'b01;
  localparam logic [1:0] XT_READ   = 2'b10;
endpackage

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] base_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  // search from base_i upward, wrapping; nearest offset wins
  always_comb begin
    int k;
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      k = int'(base_i) + i;
      if (k >= N) k = k - N;
      if (req_i[k]) begin
        valid_o = 1'b1;
        idx_o   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [1:0]       type_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             step_i,
  output logic [1:0]       type_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       type_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      type_q <= '0;
    end else if (load_i) begin
      cnt_q  <= cnt_i;
      type_q <= type_i;
    end else if (step_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign type_o = type_q;
  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int CNT_W     = 6,
  parameter int XFER_CLKS = 4,
  parameter int DW        = 8,
  parameter int AW        = 3,
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int PW = (XFER_CLKS > 1) ? $clog2(XFER_CLKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] dreq_i,
  output logic              hold_req_o,
  input  logic              hold_ack_i,
  output logic [NUM_CH-1:0] dack_no,
  output logic              mem_rd_no,
  output logic              mem_wr_no,
  output logic              io_rd_no,
  output logic              io_wr_no,
  output logic              term_cnt_o,
  input  logic              reg_cs_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o
);
  localparam logic [AW-1:0] MODE_ADDR = AW'(NUM_CH);

  dma_state_e        st_q;
  logic [CW-1:0]     sel_q, base_q, sel_inc, arb_base, arb_idx;
  logic [PW-1:0]     phase_q;
  logic [NUM_CH-1:0] en_q, tc_q, last_v, step_v, sel_oh, tc_hit;
  logic [NUM_CH-1:0] pending, arb_req;
  logic [1:0]        type_v [NUM_CH];
  logic [1:0]        cur_type;
  logic              rot_q, arb_valid, xfer_end, strobe_ph;
  logic              reg_wr, mode_wr, stat_rd;

  assign reg_wr  = reg_cs_i & reg_wr_i;
  assign mode_wr = reg_wr && reg_addr_i == MODE_ADDR;
  assign stat_rd = reg_cs_i && reg_rd_i && reg_addr_i == MODE_ADDR;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (reg_wr && reg_addr_i == AW'(c)),
      .type_i (reg_wdata_i[DW-1 -: 2]),
      .cnt_i  (reg_wdata_i[CNT_W-1:0]),
      .step_i (step_v[c]),
      .type_o (type_v[c]),
      .last_o (last_v[c])
    );
  end

  always_comb begin
    sel_oh = '0;
    if (st_q == ST_XFER) sel_oh[sel_q] = 1'b1;
  end

  assign xfer_end = (st_q == ST_XFER) && (phase_q == PW'(XFER_CLKS - 1));
  assign step_v   = xfer_end ? sel_oh : '0;
  assign tc_hit   = step_v & last_v;
  assign pending  = en_q & dreq_i;
  // channel finishing its count must not win the back-to-back arbitration
  assign arb_req  = (st_q == ST_XFER) ? (pending & ~tc_hit) : pending;
  assign sel_inc  = (sel_q == CW'(NUM_CH - 1)) ? '0 : sel_q + 1'b1;
  assign arb_base = !rot_q ? '0 : ((st_q == ST_XFER) ? sel_inc : base_q);

  dma_arb #(.N(NUM_CH)) u_arb (
    .req_i   (arb_req),
    .base_i  (arb_base),
    .valid_o (arb_valid),
    .idx_o   (arb_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sel_q   <= '0;
      base_q  <= '0;
      phase_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (|pending) st_q <= ST_HOLD;
        ST_HOLD: begin
          if (!arb_valid) st_q <= ST_IDLE;
          else if (hold_ack_i) begin
            st_q    <= ST_XFER;
            sel_q   <= arb_idx;
            phase_q <= '0;
          end
        end
        ST_XFER: begin
          if (!xfer_end) phase_q <= phase_q + 1'b1;
          else begin
            phase_q <= '0;
            base_q  <= sel_inc;
            if (arb_valid && hold_ack_i) sel_q <= arb_idx;
            else if (arb_valid)          st_q  <= ST_HOLD;
            else                         st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      rot_q <= 1'b0;
      tc_q  <= '0;
    end else begin
      if (mode_wr) begin
        en_q  <= reg_wdata_i[NUM_CH-1:0];
        rot_q <= reg_wdata_i[NUM_CH];
      end else begin
        en_q <= en_q & ~tc_hit;
      end
      tc_q <= (stat_rd ? '0 : tc_q) | tc_hit;
    end
  end

  assign cur_type   = type_v[sel_q];
  assign strobe_ph  = (st_q == ST_XFER) && (phase_q != '0) &&
                      (phase_q != PW'(XFER_CLKS - 1));
  assign hold_req_o = (st_q != ST_IDLE);
  assign dack_no    = ~sel_oh;
  assign mem_rd_no  = ~(strobe_ph && cur_type == XT_READ);
  assign io_wr_no   = ~(strobe_ph && cur_type == XT_READ);
  assign io_rd_no   = ~(strobe_ph && cur_type == XT_WRITE);
  assign mem_wr_no  = ~(strobe_ph && cur_type == XT_WRITE);
  assign term_cnt_o = xfer_end && last_v[sel_q];
  assign reg_rdata_o = stat_rd ? DW'(tc_q) : '0;
endmodule

// File: rtl/dma_req_ctrl_chk.sv
module dma_req_ctrl_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hold_req_o,
  input logic              hold_ack_i,
  input logic [NUM_CH-1:0] dack_no,
  input logic              mem_rd_no,
  input logic              mem_wr_no,
  input logic              io_rd_no,
  input logic              io_wr_no
);
  logic [1:0] ph_q;
  logic       granted, any_strobe;

  assign granted    = ~&dack_no;
  assign any_strobe = ~(mem_rd_no & mem_wr_no & io_rd_no & io_wr_no);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= granted ? ph_q + 1'b1 : 2'd0;
  end

  AST_DACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~dack_no)); // R2
  AST_XFER_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(granted) && dack_no != $past(dack_no)) |-> $past(ph_q) == 2'd3); // R2
  AST_DACK_NEEDS_HRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    granted |-> hold_req_o); // R1
  AST_STROBE_IN_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_strobe |-> granted); // R3
  AST_NO_MEM_CONFLICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_rd_no && !mem_wr_no) && !(!io_rd_no && !io_wr_no)); // R3
  AST_START_NEEDS_HLDA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (granted && dack_no != $past(dack_no)) |-> $past(hold_ack_i)); // R7
  AST_HRQ_DROP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_req_o) |-> (!granted && ($past(!granted) || $past(ph_q) == 2'd3))); // R8
endmodule

bind dma_req_ctrl dma_req_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hold_req_o (hold_req_o),
  .hold_ack_i (hold_ack_i),
  .dack_no    (dack_no),
  .mem_rd_no  (mem_rd_no),
  .mem_wr_no  (mem_wr_no),
  .io_rd_no   (io_rd_no),
  .io_wr_no   (io_wr_no)
);

// File: tb/dma_req_ctrl_tb.sv
`timescale 1ns/1ps
module dma_req_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] dreq_i = '0;
  logic       hold_req_o, hold_ack_i = 1'b0;
  logic [3:0] dack_no;
  logic       mem_rd_no, mem_wr_no, io_rd_no, io_wr_no, term_cnt_o;
  logic       reg_cs_i = 1'b0, reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;

  int total = 0, bad = 0;
  bit done_flag = 0;

  // bench model
  int         cnt_m [4];
  logic [1:0] typ_m [4];
  logic [3:0] en_m = '0, tc_m = '0;
  int         base_m = 0;
  bit         rot_m = 0;

  always #10 clk_i = ~clk_i;

  dma_req_ctrl u_dut (
    .clk_i, .rst_ni, .dreq_i, .hold_req_o, .hold_ack_i, .dack_no,
    .mem_rd_no, .mem_wr_no, .io_rd_no, .io_wr_no, .term_cnt_o,
    .reg_cs_i, .reg_wr_i, .reg_rd_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_winner(input logic [3:0] pend);
    int b;
    b = rot_m ? base_m : 0;
    for (int i = 0; i < 4; i++) if (pend[(b + i) % 4]) return (b + i) % 4;
    return -1;
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_cs_i = 1; reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_cs_i = 0; reg_wr_i = 0;
  endtask

  task automatic rd_status(input string tag);
    @(negedge clk_i);
    reg_cs_i = 1; reg_rd_i = 1; reg_addr_i = 3'd4;
    #1 chk(reg_rdata_o == {4'b0, tc_m}, tag, reg_rdata_o, {4'b0, tc_m});
    @(negedge clk_i);
    reg_cs_i = 0; reg_rd_i = 0;
    tc_m = '0;
  endtask

  task automatic cfg_chan(input int ch, input logic [1:0] t, input int n);
    wr_reg(3'(ch), {t, 6'(n)});
    typ_m[ch] = t; cnt_m[ch] = n;
  endtask

  task automatic set_mode(input logic [3:0] en, input bit rot);
    wr_reg(3'd4, {3'b0, rot, en});
    en_m = en; rot_m = rot;
  endtask

  // called at the negedge showing clock 1 of a transfer
  task automatic check_xfer(input int ch, input bit drop_hold);
    logic [3:0] ed;
    bit sr, sw;
    ed = ~(4'b1 << ch);
    chk(dack_no == ed, rot_m ? "R5 grant" : "R4 grant", dack_no, ed);
    for (int p = 0; p < 4; p++) begin
      if (p > 0) @(negedge clk_i);
      sr = (p == 1 || p == 2) && typ_m[ch] == 2'b10;
      sw = (p == 1 || p == 2) && typ_m[ch] == 2'b01;
      chk(dack_no == ed && hold_req_o, "R2 dack held", {hold_req_o, dack_no}, {1'b1, ed});
      chk({mem_rd_no, io_wr_no, io_rd_no, mem_wr_no} == {~sr, ~sr, ~sw, ~sw}, "R3 strobes",
          {mem_rd_no, io_wr_no, io_rd_no, mem_wr_no}, {~sr, ~sr, ~sw, ~sw});
      chk(term_cnt_o == (p == 3 && cnt_m[ch] == 0), "R9 term_cnt", term_cnt_o,
          (p == 3 && cnt_m[ch] == 0));
      if (drop_hold && p == 1) hold_ack_i = 1'b0;
    end
    if (cnt_m[ch] == 0) begin
      tc_m[ch] = 1'b1; en_m[ch] = 1'b0;
    end else cnt_m[ch]--;
    base_m = (ch + 1) % 4;
  endtask

  task automatic run_burst(input logic [3:0] req);
    int w;
    bit first;
    first = 1;
    dreq_i = req;
    if ((en_m & req) == 0) begin
      repeat (4) begin
        @(negedge clk_i);
        chk(!hold_req_o, "R10 disabled ignored", hold_req_o, 0);
      end
      dreq_i = '0;
      return;
    end
    while ((en_m & req) != 0) begin
      @(negedge clk_i);
      w = 0;
      while (&dack_no && w < 8) begin @(negedge clk_i); w++; end
      if (!first) chk(w == 0, "R6 no gap", w, 0);
      if (&dack_no) begin
        chk(0, "R1 grant missing", dack_no, 0);
        break;
      end
      check_xfer(exp_winner(en_m & req), 0);
      first = 0;
    end
    @(negedge clk_i);
    chk(!hold_req_o && &dack_no, "R8 hrq drop", {hold_req_o, dack_no}, 5'h0f);
    dreq_i = '0;
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 0, 1);
    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] m;
    void'($urandom(32'h1d0a5eed));
    for (int i = 0; i < 4; i++) begin cnt_m[i] = 0; typ_m[i] = 0; end
    repeat (3) @(negedge clk_i);
    chk(!hold_req_o && dack_no == 4'hf && {mem_rd_no, mem_wr_no, io_rd_no, io_wr_no} == 4'hf,
        "R1 reset idle", {hold_req_o, dack_no}, 5'h0f);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(reg_rdata_o == 0 && !hold_req_o, "R10 reset", reg_rdata_o, 0);

    // disabled channels ignored
    dreq_i = 4'hf;
    repeat (4) begin
      @(negedge clk_i);
      chk(!hold_req_o, "R10 disabled ignored", hold_req_o, 0);
    end
    dreq_i = '0;

    // hold wait, single transfer to terminal count
    cfg_chan(1, 2'b10, 0);
    set_mode(4'b0010, 0);
    hold_ack_i = 0;
    dreq_i = 4'b0010;
    @(negedge clk_i);
    chk(hold_req_o, "R1 hrq raised", hold_req_o, 1);
    repeat (3) begin
      @(negedge clk_i);
      chk(hold_req_o && &dack_no, "R1 wait hlda", {hold_req_o, dack_no}, 5'h1f);
    end
    hold_ack_i = 1;
    run_burst(4'b0010);
    rd_status("R10 status read");
    rd_status("R10 status cleared");
    run_burst(4'b0010); // en auto-cleared: R9
    set_mode(4'b1111, 0);
    rd_status("R10 not mode bits");

    // fixed priority burst, mixed types
    cfg_chan(0, 2'b10, 1); cfg_chan(1, 2'b01, 1);
    cfg_chan(2, 2'b00, 1); cfg_chan(3, 2'b11, 1);
    set_mode(4'b1111, 0);
    run_burst(4'b1111);
    rd_status("R9 all tc");

    // rotating priority burst
    for (int c = 0; c < 4; c++) cfg_chan(c, 2'(c), 1);
    set_mode(4'b1111, 1);
    run_burst(4'b1111);
    rd_status("R5 all tc");

    // hold acknowledge withdrawn mid-transfer
    cfg_chan(2, 2'b01, 2);
    set_mode(4'b0100, 0);
    dreq_i = 4'b0100;
    while (&dack_no) @(negedge clk_i);
    check_xfer(exp_winner(en_m & dreq_i), 1);
    repeat (4) begin
      @(negedge clk_i);
      chk(hold_req_o && &dack_no, "R7 paused", {hold_req_o, dack_no}, 5'h1f);
    end
    hold_ack_i = 1;
    @(negedge clk_i);
    check_xfer(exp_winner(en_m & dreq_i), 0);
    run_burst(4'b0100);
    rd_status("R7 tc after resume");

    // constrained random
    for (int it = 0; it < 40; it++) begin
      for (int c = 0; c < 4; c++) cfg_chan(c, 2'($urandom), int'($urandom % 3));
      set_mode(4'($urandom), 1'($urandom));
      m = 4'($urandom);
      run_burst(m);
      rd_status("R10 random status");
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule